// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This controller sits in the always-on part of a chip and steps one switchable logic domain through a ladder of low-power states. The lightest state stops the clock. The next one also asks for a lower voltage/frequency operating point. The deepest one saves register state, clamps the domain outputs and opens the power switches. A sleep request comes with a predicted idle length. The controller compares that length with a programmable break-even value and commits to full power removal only when the idle time is long enough to pay back the wake-up cost. Otherwise it stays in the scaled state.

A wake request brings the domain back. From the scaled state, recovery takes a few cycles. From the unpowered state, the switch groups close one at a time with a fixed gap between them, which limits in-rush current. The controller then waits for a power-good acknowledge or a settle count, restores state, drops isolation, raises the voltage/frequency, enables the clock and finally signals ready. A wake request that arrives while shutdown is under way is still honoured: the step in progress completes and the sequence unwinds in reverse order.

The analog rail is not modelled. It appears only as the power-good input and fixed cycle counts. Every output is decoded from registered state, so each output changes in the cycle after the edge that moved the sequence.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, a sleep request sampled in the active state (code 0) with wake low drops the clock enable at the next edge (state code 1). One edge later the low voltage/frequency request rises (state code 2), with the clock still off. Switches never open while the clock runs or while the low-level request is off.
- R2: The idle prediction and break-even value are sampled together with the sleep request. Deep entry happens when prediction >= break-even, equality included. Otherwise the controller stays in state 2 with every switch enable high for as long as no wake arrives.
- R3: Isolation rises (state code 3) two edges before the switches open and is high in every cycle in which any switch enable is low.
- R4: A one-cycle save strobe (state code 4) sits in the cycle just before all switch enables fall together (state code 5). A one-cycle restore strobe (state code 8) occurs only while every switch is on and isolation is still high.
- R5: A wake request sampled in state 5 turns on switch group 0 at the next edge (state code 6). Each further group, in rising index order, turns on GAP_CYC edges after the previous one, and only one group is added at a time.
- R6: GAP_CYC edges after the last group turns on, the controller enters settling (state code 7). It moves to restore at the first edge that sees power-good high, or after SETTLE_CYC edges if power-good stays low.
- R7: After restore, the following happen on successive edges: isolation falls (code 9), the low voltage/frequency request falls (code 10), the clock enable rises (code 11), and ready rises (code 0). Ready implies clock on, nominal level, no isolation and all switches on.
- R8: A wake from state 2 reaches ready three edges after it is sampled, passing through codes 10 and 11.
- R9: A wake sampled in state 1 returns through code 11 to ready. A wake sampled in state 2 takes the R8 path even when deep entry was chosen. A wake sampled in state 3 or 4 goes to code 9 and then follows R7 without opening any switch.
- R10: The power-gated entry count rises by exactly one each time state 5 is entered and never changes otherwise. The state code output is the 4-bit code of the current step as given in R1 to R9.
- R11: During and right after reset, the state code is 0, ready and the clock enable are high, every switch enable is high, isolation, save, restore and low-level request are low, and the entry count is zero.
- R12: In the active state, a sleep request that arrives together with a wake request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to leave the active state |
| idle_pred | input | IDLE_W | Predicted idle length sampled with sleep_req |
| break_even | input | IDLE_W | Programmable threshold for full power removal |
| wake_req | input | 1 | Request to return to the active state |
| pwr_good | input | 1 | Rail settled acknowledge |
| clk_en | output | 1 | Domain clock enable |
| vf_low | output | 1 | Low voltage/frequency level request |
| ret_save | output | 1 | One-cycle retention save strobe |
| ret_restore | output | 1 | One-cycle retention restore strobe |
| iso_en | output | 1 | Output clamp enable, holds domain outputs at zero |
| sw_en | output | GROUPS | Power switch group enables, bit 0 closes first |
| state_o | output | 4 | Current sequence step code |
| ready | output | 1 | Domain fully operational |
| pg_count | output | CNT_W | Count of power-gated entries |

## Verification
Each output is decoded from the state register and the switch mask register, so a stimulus sampled at an edge shows up in the cycle after that edge. The bench drives inputs on the falling edge and checks outputs on the next falling edge, once per step along the computed sequence. During wake-up, a bench function gives the exact number of edges to ready from the group count, the gap, the settle length and the power-good level. The bench checks that ready is low one cycle before that point and high at it. It checks switch group timing at every cycle of the ramp against a thermometer value computed from the cycles elapsed since the wake.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [3:0] {
    PS_ACTIVE  = 4'd0,
    PS_CLKOFF  = 4'd1,
    PS_SCALED  = 4'd2,
    PS_ISOLATE = 4'd3,
    PS_SAVE    = 4'd4,
    PS_OFF     = 4'd5,
    PS_RAMP    = 4'd6,
    PS_SETTLE  = 4'd7,
    PS_RESTORE = 4'd8,
    PS_UNISO   = 4'd9,
    PS_VFUP    = 4'd10,
    PS_CLKON   = 4'd11
  } pstate_t;
endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic [IDLE_W-1:0] idle_pred,
  input  logic [IDLE_W-1:0] break_even,
  input  logic              ramp_done,
  input  logic              settle_done,
  output pstate_t           state_q,
  output pstate_t           state_d,
  output logic [CNT_W-1:0]  pg_count
);
  logic             deep_q, deep_d, deep_en;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ACTIVE:  if (sleep_req && !wake_req) state_d = PS_CLKOFF;
      PS_CLKOFF:  state_d = wake_req ? PS_CLKON : PS_SCALED;
      PS_SCALED:  if (wake_req) state_d = PS_VFUP;
                  else if (deep_q) state_d = PS_ISOLATE;
      PS_ISOLATE: state_d = wake_req ? PS_UNISO : PS_SAVE;
      PS_SAVE:    state_d = wake_req ? PS_UNISO : PS_OFF;
      PS_OFF:     if (wake_req) state_d = PS_RAMP;
      PS_RAMP:    if (ramp_done) state_d = PS_SETTLE;
      PS_SETTLE:  if (settle_done) state_d = PS_RESTORE;
      PS_RESTORE: state_d = PS_UNISO;
      PS_UNISO:   state_d = PS_VFUP;
      PS_VFUP:    state_d = PS_CLKON;
      PS_CLKON:   state_d = PS_ACTIVE;
      default:    state_d = PS_ACTIVE;
    endcase
  end

  // depth decision taken once, with the sleep request
  assign deep_en = (state_q == PS_ACTIVE) && (state_d == PS_CLKOFF);
  assign deep_d  = (idle_pred >= break_even);

  // entry counter
  assign cnt_en = (state_q == PS_SAVE) && (state_d == PS_OFF);
  assign cnt_d  = pg_count + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_ACTIVE;
      deep_q   <= 1'b0;
      pg_count <= '0;
    end else begin
      state_q <= state_d;
      if (deep_en) deep_q   <= deep_d;
      if (cnt_en)  pg_count <= cnt_d;
    end
  end
endmodule

// File: rtl/pwr_seq_stagger.sv
module pwr_seq_stagger
  import pwr_seq_pkg::*;
#(
  parameter int GROUPS     = 4,
  parameter int GAP_CYC    = 8,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pstate_t           state_q,
  input  pstate_t           state_d,
  input  logic              pwr_good,
  output logic [GROUPS-1:0] sw_mask,
  output logic              ramp_done,
  output logic              settle_done
);
  localparam int TMR_MAX = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] GAP_LAST    = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);

  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              tmr_en;
  logic [GROUPS-1:0] mask_d;
  logic              mask_en;
  logic              in_ramp, in_settle, moving, gap_end, all_on;

  assign in_ramp   = (state_q == PS_RAMP);
  assign in_settle = (state_q == PS_SETTLE);
  assign moving    = (state_q != state_d);
  assign gap_end   = in_ramp && (tmr_q == GAP_LAST);
  assign all_on    = &sw_mask;

  assign ramp_done   = gap_end && all_on;
  assign settle_done = in_settle && (pwr_good || (tmr_q == SETTLE_LAST));

  // interval timer shared by ramp gaps and settling
  assign tmr_en = in_ramp || in_settle || moving;
  assign tmr_d  = (moving || gap_end) ? '0 : tmr_q + TMR_W'(1);

  // switch group mask: cleared on power-off, thermometer fill on ramp
  always_comb begin
    mask_d  = sw_mask;
    mask_en = 1'b0;
    if (state_q == PS_SAVE && state_d == PS_OFF) begin
      mask_d  = '0;
      mask_en = 1'b1;
    end else if (state_q == PS_OFF && state_d == PS_RAMP) begin
      mask_d  = GROUPS'(1);
      mask_en = 1'b1;
    end else if (gap_end && !all_on) begin
      mask_d  = (sw_mask << 1) | GROUPS'(1);
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      sw_mask <= '1;
    end else begin
      if (tmr_en)  tmr_q   <= tmr_d;
      if (mask_en) sw_mask <= mask_d;
    end
  end
endmodule

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode
  import pwr_seq_pkg::*;
(
  input  pstate_t state_q,
  output logic    clk_en,
  output logic    vf_low,
  output logic    ret_save,
  output logic    ret_restore,
  output logic    iso_en,
  output logic    ready
);
  always_comb begin
    clk_en      = (state_q == PS_ACTIVE) || (state_q == PS_CLKON);
    ready       = (state_q == PS_ACTIVE);
    ret_save    = (state_q == PS_SAVE);
    ret_restore = (state_q == PS_RESTORE);
    unique case (state_q)
      PS_SCALED, PS_ISOLATE, PS_SAVE, PS_OFF, PS_RAMP,
      PS_SETTLE, PS_RESTORE, PS_UNISO: vf_low = 1'b1;
      default:                         vf_low = 1'b0;
    endcase
    unique case (state_q)
      PS_ISOLATE, PS_SAVE, PS_OFF, PS_RAMP,
      PS_SETTLE, PS_RESTORE:           iso_en = 1'b1;
      default:                         iso_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int GROUPS     = 4,
  parameter int GAP_CYC    = 8,
  parameter int SETTLE_CYC = 16,
  parameter int IDLE_W     = 16,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [IDLE_W-1:0] idle_pred,
  input  logic [IDLE_W-1:0] break_even,
  input  logic              wake_req,
  input  logic              pwr_good,
  output logic              clk_en,
  output logic              vf_low,
  output logic              ret_save,
  output logic              ret_restore,
  output logic              iso_en,
  output logic [GROUPS-1:0] sw_en,
  output logic [3:0]        state_o,
  output logic              ready,
  output logic [CNT_W-1:0]  pg_count
);
  pstate_t state_q, state_d;
  logic    ramp_done, settle_done;

  pwr_seq_fsm #(.IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .wake_req    (wake_req),
    .idle_pred   (idle_pred),
    .break_even  (break_even),
    .ramp_done   (ramp_done),
    .settle_done (settle_done),
    .state_q     (state_q),
    .state_d     (state_d),
    .pg_count    (pg_count)
  );

  pwr_seq_stagger #(.GROUPS(GROUPS), .GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC)) u_stagger (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .state_d     (state_d),
    .pwr_good    (pwr_good),
    .sw_mask     (sw_en),
    .ramp_done   (ramp_done),
    .settle_done (settle_done)
  );

  pwr_seq_decode u_decode (
    .state_q     (state_q),
    .clk_en      (clk_en),
    .vf_low      (vf_low),
    .ret_save    (ret_save),
    .ret_restore (ret_restore),
    .iso_en      (iso_en),
    .ready       (ready)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int GROUPS = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              vf_low,
  input logic              ret_save,
  input logic              ret_restore,
  input logic              iso_en,
  input logic [GROUPS-1:0] sw_en,
  input logic              ready,
  input logic [CNT_W-1:0]  pg_count
);
  AST_CLK_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vf_low |-> !clk_en); // R1
  AST_OPEN_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sw_en) |-> (vf_low && !clk_en)); // R1
  AST_ISO_COVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sw_en) |-> iso_en); // R3
  AST_SAVE_BEFORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&sw_en) |-> $past(ret_save)); // R4
  AST_RESTORE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    ret_restore |-> ((&sw_en) && iso_en)); // R4
  AST_ONE_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_en) > $countones($past(sw_en)))
      |-> ($countones(sw_en) == $countones($past(sw_en)) + 1)); // R5
  AST_ISO_DROP_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (&sw_en)); // R7
  AST_READY_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (clk_en && !vf_low && !iso_en && (&sw_en))); // R7
  AST_COUNT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_count != $past(pg_count)) |-> ($past(ret_save) && (sw_en == '0))); // R10
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.GROUPS(GROUPS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .vf_low      (vf_low),
  .ret_save    (ret_save),
  .ret_restore (ret_restore),
  .iso_en      (iso_en),
  .sw_en       (sw_en),
  .ready       (ready),
  .pg_count    (pg_count)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int NG = 4;
  localparam int GP = 3;
  localparam int ST = 5;
  localparam int IW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0;
  logic [IW-1:0] idle_pred = '0;
  logic [IW-1:0] break_even = '0;
  logic          wake_req = 1'b0;
  logic          pwr_good = 1'b0;
  logic          clk_en, vf_low, ret_save, ret_restore, iso_en, ready;
  logic [NG-1:0] sw_en;
  logic [3:0]    state_o;
  logic [CW-1:0] pg_count;

  int n_chk = 0;
  int n_fail = 0;
  int pg_exp = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.GROUPS(NG), .GAP_CYC(GP), .SETTLE_CYC(ST), .IDLE_W(IW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_pred(idle_pred),
    .break_even(break_even), .wake_req(wake_req), .pwr_good(pwr_good),
    .clk_en(clk_en), .vf_low(vf_low), .ret_save(ret_save), .ret_restore(ret_restore),
    .iso_en(iso_en), .sw_en(sw_en), .state_o(state_o), .ready(ready), .pg_count(pg_count)
  );

  function automatic int therm(input int n);
    return (1 << n) - 1;
  endfunction

  function automatic int wake_lat(input bit deep, input bit pg);
    if (!deep) return 3;
    return NG * GP + (pg ? 1 : ST) + 5;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // enter sleep; stops in state 2 (shallow) or state 5 (deep)
  task automatic go_sleep(input int idle, input int be);
    bit deep = (idle >= be);
    idle_pred = IW'(idle); break_even = IW'(be); sleep_req = 1'b1;
    step();
    chk("R1 clock off", {state_o, clk_en, vf_low}, {4'd1, 1'b0, 1'b0});
    sleep_req = 1'b0;
    step();
    chk("R1 level low", {state_o, clk_en, vf_low, sw_en}, {4'd2, 1'b0, 1'b1, NG'(therm(NG))});
    if (deep) begin
      step();
      chk("R3 isolate first", {state_o, iso_en, sw_en}, {4'd3, 1'b1, NG'(therm(NG))});
      step();
      chk("R4 save strobe", {state_o, ret_save, iso_en, sw_en}, {4'd4, 1'b1, 1'b1, NG'(therm(NG))});
      step();
      pg_exp++;
      chk("R4 switches open", {state_o, ret_save, iso_en, sw_en}, {4'd5, 1'b0, 1'b1, NG'(0)});
      chk("R10 entry count", int'(pg_count), pg_exp);
    end else begin
      step(3);
      chk("R2 shallow hold", {state_o, sw_en, iso_en}, {4'd2, NG'(therm(NG)), 1'b0});
    end
  endtask

  // full wake from state 5 with per-cycle checks
  task automatic wake_deep(input bit pg);
    pwr_good = pg; wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    for (int k = 1; k <= NG * GP; k++) begin
      chk("R5 group ramp", {state_o, sw_en}, {4'd6, NG'(therm(1 + (k - 1) / GP))});
      step();
    end
    chk("R6 settle entry", {state_o, sw_en, iso_en}, {4'd7, NG'(therm(NG)), 1'b1});
    if (!pg) begin
      for (int j = 1; j < ST; j++) begin
        step();
        chk("R6 settle count", int'(state_o), 7);
      end
    end
    step();
    chk("R4 restore strobe", {state_o, ret_restore, iso_en}, {4'd8, 1'b1, 1'b1});
    step();
    chk("R7 iso release", {state_o, iso_en, vf_low, clk_en, ret_restore}, {4'd9, 1'b0, 1'b1, 1'b0, 1'b0});
    step();
    chk("R7 level up", {state_o, vf_low, clk_en}, {4'd10, 1'b0, 1'b0});
    step();
    chk("R7 clock on", {state_o, clk_en, ready}, {4'd11, 1'b1, 1'b0});
    step();
    chk("R7 ready", {state_o, ready}, {4'd0, 1'b1});
    pwr_good = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R11 reset outputs", {state_o, ready, clk_en, sw_en, iso_en, ret_save, ret_restore, vf_low},
        {4'd0, 1'b1, 1'b1, NG'(therm(NG)), 4'b0000});
    rst_n = 1'b1;
    step();
    chk("R11 after reset", {state_o, ready, sw_en, iso_en, vf_low}, {4'd0, 1'b1, NG'(therm(NG)), 2'b00});
    chk("R11 count zero", int'(pg_count), 0);

    // R12: sleep together with wake is ignored
    sleep_req = 1'b1; wake_req = 1'b1;
    step();
    sleep_req = 1'b0; wake_req = 1'b0;
    chk("R12 sleep ignored", {state_o, ready, clk_en}, {4'd0, 1'b1, 1'b1});

    // shallow: prediction one below threshold, wake from scaled (R8)
    go_sleep(99, 100);
    wake_req = 1'b1; step(); wake_req = 1'b0;
    chk("R8 light wake 1", {state_o, vf_low, clk_en}, {4'd10, 1'b0, 1'b0});
    step();
    chk("R8 light wake 2", {state_o, clk_en, ready}, {4'd11, 1'b1, 1'b0});
    step();
    chk("R8 light wake 3", {state_o, ready}, {4'd0, 1'b1});

    // deep at equality, wake without power-good, then with power-good
    go_sleep(100, 100);
    step(4);
    chk("R4 held off", {state_o, sw_en, iso_en}, {4'd5, NG'(0), 1'b1});
    wake_deep(1'b0);
    go_sleep(500, 20);
    wake_deep(1'b1);

    // R9: wake during clock-off step
    sleep_req = 1'b1; idle_pred = IW'(900); break_even = IW'(1);
    step();
    sleep_req = 1'b0; wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R9 unwind from clock-off", {state_o, clk_en, vf_low}, {4'd11, 1'b1, 1'b0});
    step();
    chk("R9 ready after clock-off", {state_o, ready}, {4'd0, 1'b1});

    // R9: wake in scaled with deep chosen
    sleep_req = 1'b1; step(); sleep_req = 1'b0; step();
    wake_req = 1'b1; step(); wake_req = 1'b0;
    chk("R9 scaled deep wake", {state_o, iso_en}, {4'd10, 1'b0});
    step(2);
    chk("R9 scaled deep ready", {state_o, ready}, {4'd0, 1'b1});

    // R9: wake in isolate and in save steps
    for (int s = 0; s < 2; s++) begin
      sleep_req = 1'b1; step(); sleep_req = 1'b0; step(2 + s);
      chk("R9 reached step", int'(state_o), 3 + s);
      wake_req = 1'b1; step(); wake_req = 1'b0;
      chk("R9 unwind no open", {state_o, sw_en, iso_en, vf_low}, {4'd9, NG'(therm(NG)), 1'b0, 1'b1});
      chk("R10 count unchanged", int'(pg_count), pg_exp);
      step(3);
      chk("R9 unwind ready", {state_o, ready}, {4'd0, 1'b1});
    end

    // random mix
    void'($urandom(32'd2024));
    for (int it = 0; it < 40; it++) begin
      int idle = $urandom_range(0, 300);
      int be   = (it % 5 == 0) ? idle : $urandom_range(0, 300);
      bit deep = (idle >= be);
      bit pg   = $urandom_range(0, 1);
      int lat  = wake_lat(deep, pg);
      go_sleep(idle, be);
      step($urandom_range(0, 4));
      chk("R2 depth decision", int'(state_o), deep ? 5 : 2);
      pwr_good = pg; wake_req = 1'b1; step(); wake_req = 1'b0;
      step(lat - 2);
      chk("R7 not ready early", int'(ready), 0);
      step();
      chk("R7 ready on time", {state_o, ready}, {4'd0, 1'b1});
      chk("R10 running count", int'(pg_count), pg_exp);
      pwr_good = 1'b0;
      step($urandom_range(0, 2));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule